// File: doc/BRIEF.md
# Multi-File Physical Register Occupancy Tracker

This block keeps live occupancy counts for a small set of physical register files while a rename stage hands out and retires destination mappings. Each architectural register has a programmable table entry that names the file which owns it and how many physical registers one mapping of it costs. File 0 is a shared global pool: every allocation and every release is charged to it as well, in addition to the owning file when the owner is nonzero.

Rename logic uses three functions. The allocate port charges one destination per cycle. The free port releases one per cycle. The query port takes up to four destination registers and returns, combinationally, one bit per file telling whether that group of destinations would overflow the file. A capacity of zero marks a file as unbounded. A request larger than a whole file is trimmed to that file's capacity before it is compared. Writes that are zero idioms, eliminated moves, or partial writes merged into a wider register are flagged by the caller, and they neither take nor return physical registers.

Top module: `prf_occupancy_tracker`

## Requirements
- R1: After reset every occupancy count is 0, every capacity is 0 (unbounded), and every register entry has owner 0 and cost 1.
- R2: A configuration write with cfg_kind=0 sets the capacity of file cfg_idx[1:0] to cfg_data. With cfg_kind=1 it sets the entry of register cfg_idx: owner = cfg_data[1:0], cost = cfg_data[4:2]. The new value is used from the next cycle on.
- R3: An allocation adds the register's cost to file 0. If the owner is nonzero, it also adds the cost to the owning file. The counts change one cycle after the request.
- R4: A release subtracts the register's cost in the same way, from file 0 and from the owning file when the owner is nonzero.
- R5: An allocation or release flagged as zero idiom, eliminated move or merged partial write leaves every count unchanged.
- R6: An allocation and a release in the same cycle are applied together as one net change per file.
- R7: Counts saturate: a release larger than the count leaves 0, and an allocation past the top value leaves the top value.
- R8: The query adds up the costs of the valid destinations for each file, with file 0 collecting all of them. It sets bit I of full_mask when capacity(I) < used(I) + requested(I).
- R9: A request larger than a file's capacity is trimmed to that capacity before the comparison, so a file with a count of 0 never reports full.
- R10: A file with capacity 0 never reports full. A file with no requested cost never reports full.
- R11: The query result is based on the counts held before the current cycle's allocate and release take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 = file capacity, 1 = register entry |
| cfg_idx | input | 4 | File index (low bits) or register number |
| cfg_data | input | 8 | Capacity, or {cost, owner} for an entry |
| alloc_vld | input | 1 | Allocate request |
| alloc_reg | input | 4 | Register being allocated |
| alloc_zero | input | 1 | Allocation is a zero idiom |
| alloc_elim | input | 1 | Allocation is an eliminated move |
| alloc_merged | input | 1 | Allocation is a merged partial write |
| free_vld | input | 1 | Release request |
| free_reg | input | 4 | Register being released |
| free_zero | input | 1 | Release of a zero idiom write |
| free_elim | input | 1 | Release of an eliminated move |
| free_merged | input | 1 | Release of a merged partial write |
| qry_vld | input | 4 | Valid bit for each query destination |
| qry_reg | input | 16 | Four packed query destination registers |
| full_mask | output | 4 | One bit per file that lacks capacity |
| used_cnt | output | 32 | Four packed 8-bit occupancy counts |

## Verification
Allocation and release can land in the same cycle and touch the same file. The bench provokes this by freeing one register of a file while allocating another register of that file, and judges the result by the single net count seen one cycle later. Query and allocation can also coincide. The bench holds a query steady while an allocation that fills the queried file is applied. It then compares full_mask just before the clock edge, where the pre-update counts must decide it, with full_mask after the edge, where the bit has to turn on.

// File: rtl/prf_occ_pkg.sv
package prf_occ_pkg;

   typedef enum logic {
      CFG_CAPACITY = 1'b0,
      CFG_ENTRY    = 1'b1
   } cfg_kind_e;

endpackage

// File: rtl/prf_cost_table.sv
module prf_cost_table #(
   parameter int NUM_ARCH  = 16,
   parameter int FILE_W    = 2,
   parameter int COST_W    = 3,
   parameter int NUM_PORTS = 6,
   localparam int ARCH_W   = $clog2(NUM_ARCH)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ARCH_W-1:0]             wr_reg,
   input  logic [FILE_W-1:0]             wr_file,
   input  logic [COST_W-1:0]             wr_cost,
   input  logic [NUM_PORTS*ARCH_W-1:0]   rd_reg,
   output logic [NUM_PORTS*FILE_W-1:0]   rd_file,
   output logic [NUM_PORTS*COST_W-1:0]   rd_cost
);

   if (NUM_ARCH != (1 << ARCH_W)) begin : g_bad_arch
      $error("prf_cost_table: NUM_ARCH must be a power of two");
   end

   logic [FILE_W-1:0] own_q  [NUM_ARCH];
   logic [COST_W-1:0] cost_q [NUM_ARCH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_ARCH; i++) begin
            own_q[i]  <= '0;
            cost_q[i] <= COST_W'(1);
         end
      end else if (wr_en) begin
         own_q[wr_reg]  <= wr_file;
         cost_q[wr_reg] <= wr_cost;
      end
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
      assign rd_file[p*FILE_W +: FILE_W] = own_q[rd_reg[p*ARCH_W +: ARCH_W]];
      assign rd_cost[p*COST_W +: COST_W] = cost_q[rd_reg[p*ARCH_W +: ARCH_W]];
   end

endmodule

// File: rtl/prf_file_counter.sv
module prf_file_counter #(
   parameter int CNT_W  = 8,
   parameter int COST_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_we,
   input  logic [CNT_W-1:0]  cap_wdata,
   input  logic [COST_W-1:0] add_amt,
   input  logic [COST_W-1:0] sub_amt,
   output logic [CNT_W-1:0]  used,
   output logic [CNT_W-1:0]  cap
);

   localparam int EXT_W = CNT_W + 1;
   localparam logic [EXT_W-1:0] TOP_V = {1'b0, {CNT_W{1'b1}}};

   if (COST_W >= CNT_W) begin : g_bad_cost
      $error("prf_file_counter: cost must be narrower than the counter");
   end

   logic [EXT_W-1:0] grown, diff;
   logic [CNT_W-1:0] used_nxt;

   always_comb begin
      grown = {1'b0, used} + EXT_W'(add_amt);
      diff  = grown - EXT_W'(sub_amt);
      if (grown < EXT_W'(sub_amt))
         used_nxt = '0;
      else if (diff > TOP_V)
         used_nxt = '1;
      else
         used_nxt = diff[CNT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used <= '0;
         cap  <= '0;
      end else begin
         used <= used_nxt;
         if (cap_we) cap <= cap_wdata;
      end
   end

   // R7
   floor_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (add_amt == '0 && CNT_W'(sub_amt) >= used) |=> (used == '0));

   // R6
   net_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (add_amt == sub_amt) |=> $stable(used));

   // R2
   cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_we |=> $stable(cap));

endmodule

// File: rtl/prf_avail_check.sv
module prf_avail_check #(
   parameter int NUM_DST = 4,
   parameter int FILE_W  = 2,
   parameter int COST_W  = 3,
   parameter int CNT_W   = 8,
   parameter int FILE_ID = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_DST-1:0]        dst_vld,
   input  logic [NUM_DST*FILE_W-1:0] dst_file,
   input  logic [NUM_DST*COST_W-1:0] dst_cost,
   input  logic [CNT_W-1:0]          used,
   input  logic [CNT_W-1:0]          cap,
   output logic                      full
);

   localparam int REQ_W = COST_W + $clog2(NUM_DST) + 1;
   localparam int CMP_W = ((REQ_W > CNT_W) ? REQ_W : CNT_W) + 1;

   logic [NUM_DST-1:0] hit;
   logic [REQ_W-1:0]   req;
   logic [CMP_W-1:0]   req_ext, cap_ext, trimmed;

   for (genvar d = 0; d < NUM_DST; d++) begin : g_hit
      if (FILE_ID == 0) begin : g_global
         assign hit[d] = dst_vld[d];
      end else begin : g_owned
         assign hit[d] = dst_vld[d] && (dst_file[d*FILE_W +: FILE_W] == FILE_W'(FILE_ID));
      end
   end

   always_comb begin
      req = '0;
      for (int d = 0; d < NUM_DST; d++)
         if (hit[d]) req = req + REQ_W'(dst_cost[d*COST_W +: COST_W]);
   end

   always_comb begin
      req_ext = CMP_W'(req);
      cap_ext = CMP_W'(cap);
      trimmed = (req_ext > cap_ext) ? cap_ext : req_ext;
      full    = (req != '0) && (cap != '0) && (cap_ext < (CMP_W'(used) + trimmed));
   end

   // R10
   unbounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap == '0) |-> !full);

   // R9
   empty_file_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (used == '0) |-> !full);

   // R8
   overfull_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap != '0 && used >= cap && req != '0) |-> full);

endmodule

// File: rtl/prf_occupancy_tracker.sv
module prf_occupancy_tracker #(
   parameter int NUM_FILES = 4,
   parameter int NUM_ARCH  = 16,
   parameter int NUM_DST   = 4,
   parameter int CNT_W     = 8,
   parameter int COST_W    = 3,
   localparam int ARCH_W   = $clog2(NUM_ARCH),
   localparam int FILE_W   = (NUM_FILES > 1) ? $clog2(NUM_FILES) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic                       cfg_kind,
   input  logic [ARCH_W-1:0]          cfg_idx,
   input  logic [CNT_W-1:0]           cfg_data,
   input  logic                       alloc_vld,
   input  logic [ARCH_W-1:0]          alloc_reg,
   input  logic                       alloc_zero,
   input  logic                       alloc_elim,
   input  logic                       alloc_merged,
   input  logic                       free_vld,
   input  logic [ARCH_W-1:0]          free_reg,
   input  logic                       free_zero,
   input  logic                       free_elim,
   input  logic                       free_merged,
   input  logic [NUM_DST-1:0]         qry_vld,
   input  logic [NUM_DST*ARCH_W-1:0]  qry_reg,
   output logic [NUM_FILES-1:0]       full_mask,
   output logic [NUM_FILES*CNT_W-1:0] used_cnt
);
   import prf_occ_pkg::*;

   localparam int NUM_PORTS = NUM_DST + 2;

   if (NUM_FILES < 1 || NUM_FILES > 4) begin : g_bad_files
      $error("prf_occupancy_tracker: NUM_FILES must be 1 to 4");
   end
   if (NUM_DST < 1 || NUM_DST > 4) begin : g_bad_dst
      $error("prf_occupancy_tracker: NUM_DST must be 1 to 4");
   end
   if (FILE_W + COST_W > CNT_W || FILE_W > ARCH_W) begin : g_bad_cfg
      $error("prf_occupancy_tracker: configuration fields do not fit");
   end

   logic                         tbl_we;
   logic [NUM_PORTS*FILE_W-1:0]  tbl_file;
   logic [NUM_PORTS*COST_W-1:0]  tbl_cost;
   logic                         alloc_do, free_do;
   logic [FILE_W-1:0]            a_file, f_file;
   logic [COST_W-1:0]            a_cost, f_cost;

   assign tbl_we   = cfg_we && (cfg_kind_e'(cfg_kind) == CFG_ENTRY);
   assign alloc_do = alloc_vld && !alloc_zero && !alloc_elim && !alloc_merged;
   assign free_do  = free_vld && !free_zero && !free_elim && !free_merged;
   assign a_file   = tbl_file[0 +: FILE_W];
   assign f_file   = tbl_file[FILE_W +: FILE_W];
   assign a_cost   = tbl_cost[0 +: COST_W];
   assign f_cost   = tbl_cost[COST_W +: COST_W];

   prf_cost_table #(
      .NUM_ARCH (NUM_ARCH),
      .FILE_W   (FILE_W),
      .COST_W   (COST_W),
      .NUM_PORTS(NUM_PORTS)
   ) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (tbl_we),
      .wr_reg (cfg_idx),
      .wr_file(cfg_data[FILE_W-1:0]),
      .wr_cost(cfg_data[FILE_W +: COST_W]),
      .rd_reg ({qry_reg, free_reg, alloc_reg}),
      .rd_file(tbl_file),
      .rd_cost(tbl_cost)
   );

   for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
      logic [COST_W-1:0] add_amt, sub_amt;
      logic [CNT_W-1:0]  used_f, cap_f;
      logic              cap_we;

      assign cap_we = cfg_we && (cfg_kind_e'(cfg_kind) == CFG_CAPACITY)
                      && (cfg_idx[FILE_W-1:0] == FILE_W'(f));

      if (f == 0) begin : g_global
         assign add_amt = alloc_do ? a_cost : '0;
         assign sub_amt = free_do  ? f_cost : '0;
      end else begin : g_owned
         assign add_amt = (alloc_do && a_file == FILE_W'(f)) ? a_cost : '0;
         assign sub_amt = (free_do  && f_file == FILE_W'(f)) ? f_cost : '0;
      end

      prf_file_counter #(
         .CNT_W (CNT_W),
         .COST_W(COST_W)
      ) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .cap_we   (cap_we),
         .cap_wdata(cfg_data),
         .add_amt  (add_amt),
         .sub_amt  (sub_amt),
         .used     (used_f),
         .cap      (cap_f)
      );

      prf_avail_check #(
         .NUM_DST(NUM_DST),
         .FILE_W (FILE_W),
         .COST_W (COST_W),
         .CNT_W  (CNT_W),
         .FILE_ID(f)
      ) u_avail (
         .clk     (clk),
         .rst_n   (rst_n),
         .dst_vld (qry_vld),
         .dst_file(tbl_file[2*FILE_W +: NUM_DST*FILE_W]),
         .dst_cost(tbl_cost[2*COST_W +: NUM_DST*COST_W]),
         .used    (used_f),
         .cap     (cap_f),
         .full    (full_mask[f])
      );

      assign used_cnt[f*CNT_W +: CNT_W] = used_f;
   end

   // R10
   idle_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (qry_vld == '0) |-> (full_mask == '0));

   // R5
   suppressed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!alloc_vld || alloc_zero || alloc_elim || alloc_merged) &&
       (!free_vld || free_zero || free_elim || free_merged)) |=> $stable(used_cnt));

endmodule

// File: tb/prf_occupancy_tracker_bench.sv
`timescale 1ns/1ps
module prf_occupancy_tracker_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we, cfg_kind;
   logic [3:0]  cfg_idx;
   logic [7:0]  cfg_data;
   logic        alloc_vld, alloc_zero, alloc_elim, alloc_merged;
   logic [3:0]  alloc_reg;
   logic        free_vld, free_zero, free_elim, free_merged;
   logic [3:0]  free_reg;
   logic [3:0]  qry_vld;
   logic [15:0] qry_reg;
   logic [3:0]  full_mask;
   logic [31:0] used_cnt;

   always #10 clk = ~clk;

   prf_occupancy_tracker u_prf_occupancy_tracker (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
      .alloc_vld(alloc_vld), .alloc_reg(alloc_reg), .alloc_zero(alloc_zero),
      .alloc_elim(alloc_elim), .alloc_merged(alloc_merged),
      .free_vld(free_vld), .free_reg(free_reg), .free_zero(free_zero),
      .free_elim(free_elim), .free_merged(free_merged),
      .qry_vld(qry_vld), .qry_reg(qry_reg),
      .full_mask(full_mask), .used_cnt(used_cnt)
   );

   // reference model state
   int m_own [16];
   int m_cost[16];
   int m_cap [4];
   int m_used[4];

   typedef struct {
      string tag;
      int    sel;   // 0..3 count of that file, 4 = full mask
      int    exp;
   } sb_item_t;

   sb_item_t sb_q[$];
   event     mon_ev;
   int       n_vec = 0;
   int       n_bad = 0;
   bit       done  = 1'b0;

   // monitor: pops expected items and compares with the outputs
   initial begin
      forever begin
         @(mon_ev);
         while (sb_q.size() > 0) begin
            sb_item_t it;
            int act;
            it = sb_q.pop_front();
            act = (it.sel == 4) ? int'(full_mask) : int'(used_cnt[it.sel*8 +: 8]);
            n_vec++;
            if (act != it.exp) begin
               n_bad++;
               $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.tag, it.sel, act, it.exp);
            end
         end
      end
   end

   task automatic flush();
      ->mon_ev;
      wait (sb_q.size() == 0);
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int m_mask(input logic [3:0] vld, input int r[4]);
      int res = 0;
      for (int f = 0; f < 4; f++) begin
         int req = 0;
         for (int d = 0; d < 4; d++)
            if (vld[d] && (f == 0 || m_own[r[d]] == f)) req += m_cost[r[d]];
         if (req != 0 && m_cap[f] != 0) begin
            int t = (req > m_cap[f]) ? m_cap[f] : req;
            if (m_cap[f] < m_used[f] + t) res |= (1 << f);
         end
      end
      return res;
   endfunction

   task automatic expect_used(input string tag);
      for (int f = 0; f < 4; f++) sb_q.push_back('{tag, f, m_used[f]});
      flush();
   endtask

   task automatic set_query(input logic [3:0] vld, input int r[4]);
      qry_vld = vld;
      for (int d = 0; d < 4; d++) qry_reg[d*4 +: 4] = 4'(r[d]);
   endtask

   task automatic check_query(input string tag, input logic [3:0] vld, input int r[4]);
      set_query(vld, r);
      #1;
      sb_q.push_back('{tag, 4, m_mask(vld, r)});
      flush();
   endtask

   task automatic set_cap(input int f, input int v);
      cfg_we = 1; cfg_kind = 0; cfg_idx = 4'(f); cfg_data = 8'(v);
      tick();
      cfg_we = 0;
      m_cap[f] = v;
   endtask

   task automatic set_entry(input int r, input int own, input int cost);
      cfg_we = 1; cfg_kind = 1; cfg_idx = 4'(r); cfg_data = 8'((cost << 2) | own);
      tick();
      cfg_we = 0;
      m_own[r] = own; m_cost[r] = cost;
   endtask

   // flags: {merged, elim, zero}
   task automatic drive_op(input bit av, input int ar, input logic [2:0] af,
                           input bit fv, input int fr, input logic [2:0] ff);
      alloc_vld = av; alloc_reg = 4'(ar); {alloc_merged, alloc_elim, alloc_zero} = af;
      free_vld  = fv; free_reg  = 4'(fr); {free_merged, free_elim, free_zero} = ff;
   endtask

   task automatic commit_op();
      int add[4];
      int sub[4];
      for (int f = 0; f < 4; f++) begin add[f] = 0; sub[f] = 0; end
      if (alloc_vld && !alloc_zero && !alloc_elim && !alloc_merged) begin
         add[0] += m_cost[alloc_reg];
         if (m_own[alloc_reg] != 0) add[m_own[alloc_reg]] += m_cost[alloc_reg];
      end
      if (free_vld && !free_zero && !free_elim && !free_merged) begin
         sub[0] += m_cost[free_reg];
         if (m_own[free_reg] != 0) sub[m_own[free_reg]] += m_cost[free_reg];
      end
      tick();
      for (int f = 0; f < 4; f++) begin
         int n = m_used[f] + add[f] - sub[f];
         m_used[f] = (n < 0) ? 0 : ((n > 255) ? 255 : n);
      end
      drive_op(0, 0, 3'b000, 0, 0, 3'b000);
   endtask

   task automatic do_op(input bit av, input int ar, input logic [2:0] af,
                        input bit fv, input int fr, input logic [2:0] ff);
      drive_op(av, ar, af, fv, fr, ff);
      commit_op();
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (all R) actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int q[4];
      for (int i = 0; i < 16; i++) begin m_own[i] = 0; m_cost[i] = 1; end
      for (int f = 0; f < 4; f++) begin m_cap[f] = 0; m_used[f] = 0; end
      rst_n = 0; cfg_we = 0; cfg_kind = 0; cfg_idx = 0; cfg_data = 0;
      drive_op(0, 0, 3'b000, 0, 0, 3'b000);
      qry_vld = 0; qry_reg = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1: reset counts zero, unbounded capacity, default cost 1 owner 0
      expect_used("R1 reset counts");
      q = '{0, 0, 0, 0};
      check_query("R1 reset query unbounded", 4'b1111, q);
      do_op(1, 7, 3'b000, 0, 0, 3'b000);
      expect_used("R1 default entry cost 1 owner 0");
      do_op(0, 0, 3'b000, 1, 7, 3'b000);

      // R2: configuration
      set_cap(0, 20); set_cap(1, 6); set_cap(2, 4); set_cap(3, 0);
      set_entry(1, 1, 2); set_entry(2, 2, 1); set_entry(3, 3, 3);
      set_entry(4, 0, 1); set_entry(5, 1, 3);

      // R3: allocation to owned and global files
      do_op(1, 1, 3'b000, 0, 0, 3'b000);
      expect_used("R3 alloc owned file");
      do_op(1, 4, 3'b000, 0, 0, 3'b000);
      expect_used("R3 alloc global-only register");
      do_op(1, 3, 3'b000, 0, 0, 3'b000);
      expect_used("R3 R2 alloc with configured cost");

      // R5: suppressed writes
      do_op(1, 2, 3'b001, 0, 0, 3'b000);
      expect_used("R5 zero idiom alloc");
      do_op(1, 2, 3'b010, 0, 0, 3'b000);
      expect_used("R5 eliminated alloc");
      do_op(1, 2, 3'b100, 1, 1, 3'b100);
      expect_used("R5 merged alloc and merged free");
      do_op(0, 0, 3'b000, 1, 1, 3'b001);
      expect_used("R5 zero idiom free");

      // R6: same-cycle alloc and free
      do_op(1, 5, 3'b000, 1, 1, 3'b000);
      expect_used("R6 net alloc and free");

      // R8: query sums per file
      q = '{5, 5, 0, 0};
      check_query("R8 two dests overflow file1", 4'b0011, q);
      q = '{1, 0, 0, 0};
      check_query("R8 single dest fits", 4'b0001, q);
      do_op(1, 5, 3'b000, 0, 0, 3'b000);
      expect_used("R3 fill file1");
      q = '{1, 0, 0, 0};
      check_query("R8 full file1 reports", 4'b0001, q);
      q = '{3, 5, 1, 0};
      check_query("R8 masked dest ignored", 4'b0011, q);

      // R10: unbounded file and zero-request file
      q = '{3, 3, 3, 3};
      check_query("R10 unbounded file3 global bit set", 4'b1111, q);
      q = '{3, 0, 0, 0};
      check_query("R10 full file1 not requested", 4'b0001, q);

      // R9: request above capacity is trimmed
      set_entry(6, 2, 5);
      q = '{6, 0, 0, 0};
      check_query("R9 trimmed request on empty file", 4'b0001, q);

      // R11: query sees counts before same-cycle update
      q = '{2, 0, 0, 0};
      set_query(4'b0001, q);
      drive_op(1, 6, 3'b000, 0, 0, 3'b000);
      #1;
      sb_q.push_back('{"R11 query before update", 4, m_mask(4'b0001, q)});
      flush();
      commit_op();
      #1;
      sb_q.push_back('{"R11 query after update", 4, m_mask(4'b0001, q)});
      flush();
      expect_used("R3 alloc file2");
      qry_vld = 0;

      // R7: saturation at zero
      do_op(0, 0, 3'b000, 1, 3, 3'b000);
      expect_used("R4 free owned file");
      do_op(0, 0, 3'b000, 1, 3, 3'b000);
      expect_used("R7 free below zero saturates");

      // R4: release
      do_op(0, 0, 3'b000, 1, 1, 3'b000);
      expect_used("R4 free file1");

      // R7: top saturation on global file
      set_entry(8, 0, 7);
      for (int i = 0; i < 40; i++) do_op(1, 8, 3'b000, 0, 0, 3'b000);
      expect_used("R7 saturate at top value");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule